// File: doc/BRIEF.md
# DMA Channel Register Bank

This block is the software-facing control and status front end for a single DMA channel. Software programs a staged descriptor (configuration, byte count, destination and source) through a simple register bus. It then sets the run bit in the control word. At that moment the staged values are copied into a second set of read-only execution registers and a one-cycle start pulse goes to the copy engine. While the transfer runs, the engine reports progress beats. Each beat advances the execution addresses and reduces the remaining count, so software can watch live progress while it stages the next descriptor.

The engine ends a transfer with a done or an error indication. The control word records each outcome in a sticky flag that software acknowledges by writing zero to it. When the repeat bit of the running configuration is set, a successful finish restores the execution count and addresses to their starting values. Two level interrupt lines are each gated by their own enable bit.

Top module: `dma_chan_regs`

## Requirements
- R1: After reset every register reads zero, `irq_done`, `irq_err` and `eng_start` are low, and `bus_rdata` is zero.
- R2: Staged registers are mapped at byte offsets 0x004 (32-bit configuration), 0x008 (count), 0x010 (destination) and 0x018 (source). The last three are 64 bits wide. A 4-byte access reaches the low half at the base offset and the high half at base+4. An 8-byte access at an 8-aligned offset covers both halves, with the low word in bits 31:0. Read data appears in the cycle after the request, with `bus_rvalid` high.
- R3: A write to the control word at 0x000 with bit 1 (run) set while idle does three things. It clears bit 30 (done) and bit 31 (error). It copies the staged registers into the execution registers at 0x104, 0x108, 0x110 and 0x118. It raises `eng_start` for exactly the one cycle after the write.
- R4: While a transfer is busy, an `eng_adv` cycle adds `eng_adv_bytes` to the execution source and destination and subtracts it from the execution count. It has no effect while idle.
- R5: `eng_done` while busy clears run (bit 1), sets done (bit 30) and ends the busy state.
- R6: `eng_err` while busy sets error (bit 31), leaves run unchanged and ends the busy state. When both arrive in the same cycle, the error outcome wins and done stays clear.
- R7: When configuration bit 2 (repeat) was set at start, a successful finish restores the execution count, destination and source to the values captured at start. Staged writes made during the transfer do not affect the restore. Without repeat the execution registers keep their final values.
- R8: `irq_done` is high exactly when control bits 14 and 30 are both set, and `irq_err` exactly when bits 15 and 31 are both set. Both follow a control write in the next cycle, so writing 0 to a flag drops its line.
- R9: Writes to the execution registers have no effect.
- R10: The following accesses are ignored, and reads of them return zero: accesses to unmapped offsets, accesses whose address bits 1:0 are nonzero, and 8-byte accesses with address bit 2 set.
- R11: A control write with run set while busy starts nothing. It leaves the execution registers and flags unchanged and updates only bits 0, 14 and 15.
- R12: Control bits 0 (claim), 14 and 15 read back as written. Control bits other than 0, 1, 14, 15, 30 and 31 always read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_req | input | 1 | Access request for this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_wide | input | 1 | 1 = 8-byte access, 0 = 4-byte access |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wdata | input | 64 | Write data, little-endian |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read |
| bus_rdata | output | 64 | Read data |
| eng_start | output | 1 | One-cycle start pulse to the copy engine |
| eng_cfg | output | 32 | Execution configuration |
| eng_bytes | output | 64 | Execution remaining byte count |
| eng_dst | output | 64 | Execution destination address |
| eng_src | output | 64 | Execution source address |
| eng_adv | input | 1 | Engine progress beat |
| eng_adv_bytes | input | 64 | Bytes moved by the beat |
| eng_done | input | 1 | Engine finished successfully |
| eng_err | input | 1 | Engine failed |
| irq_done | output | 1 | Done interrupt, level |
| irq_err | output | 1 | Error interrupt, level |

## Verification
The hardest states to reach are those where software acts while the engine is still mid-transfer. Three cases matter: a second run request arriving while busy, staged registers rewritten before a repeat finish, and done and error arriving together. The bench holds back the engine completion pulse so that these bus writes land inside the busy window. It first issues progress beats, which move the execution registers away from their start values; a restore from the captured values is then visible at the ports and cannot be mistaken for unchanged state.

// File: rtl/dmab_pkg.sv
package dmab_pkg;
   // control word bit positions
   localparam int unsigned CB_CLAIM = 0;
   localparam int unsigned CB_RUN   = 1;
   localparam int unsigned CB_DIE   = 14;
   localparam int unsigned CB_EIE   = 15;
   localparam int unsigned CB_DONE  = 30;
   localparam int unsigned CB_ERR   = 31;
   localparam int unsigned CFG_REPEAT = 2;

   localparam logic [31:0] CTRL_KEEP = (32'd1 << CB_CLAIM) | (32'd1 << CB_RUN) |
                                       (32'd1 << CB_DIE) | (32'd1 << CB_EIE) |
                                       (32'd1 << CB_DONE) | (32'd1 << CB_ERR);
   localparam logic [31:0] CTRL_SW_BUSY = (32'd1 << CB_CLAIM) | (32'd1 << CB_DIE) |
                                          (32'd1 << CB_EIE);

   // 32-bit word indices (byte offset / 4)
   localparam int unsigned W_CTRL = 0;
   localparam int unsigned W_NCFG = 1;
   localparam int unsigned W_NBYT = 2;
   localparam int unsigned W_NDST = 4;
   localparam int unsigned W_NSRC = 6;
   localparam int unsigned W_XCFG = 65;
   localparam int unsigned W_XBYT = 66;
   localparam int unsigned W_XDST = 68;
   localparam int unsigned W_XSRC = 70;

   // number of 64-bit staged descriptor registers
   localparam int unsigned N_STAGE = 3;
endpackage

// File: rtl/dmab_stage.sv
module dmab_stage #(
   parameter int unsigned NREG   = 3,
   parameter int unsigned XFER_W = 64
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [2*NREG-1:0]          we,
   input  logic [2*NREG-1:0][31:0]    wd,
   output logic [NREG-1:0][63:0]      q
);
   localparam logic [63:0] XM = (XFER_W >= 64) ? {64{1'b1}} : ((64'd1 << XFER_W) - 64'd1);

   logic [2*NREG-1:0][31:0] half_q;

   for (genvar i = 0; i < 2*NREG; i++) begin : g_half
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)     half_q[i] <= '0;
         else if (we[i]) half_q[i] <= wd[i];
      end
   end

   for (genvar r = 0; r < NREG; r++) begin : g_reg
      assign q[r] = {half_q[2*r+1], half_q[2*r]} & XM;
   end
endmodule

// File: rtl/dmab_exec.sv
module dmab_exec
   import dmab_pkg::*;
#(
   parameter int unsigned XFER_W      = 64,
   parameter bit          SNAP_RELOAD = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        load,
   input  logic        busy,
   input  logic        adv,
   input  logic [63:0] adv_amt,
   input  logic        done_ok,
   input  logic [31:0] n_cfg,
   input  logic [63:0] n_bytes,
   input  logic [63:0] n_dst,
   input  logic [63:0] n_src,
   output logic [31:0] x_cfg,
   output logic [63:0] x_bytes,
   output logic [63:0] x_dst,
   output logic [63:0] x_src
);
   localparam logic [63:0] XM = (XFER_W >= 64) ? {64{1'b1}} : ((64'd1 << XFER_W) - 64'd1);

   logic [63:0] rb, rd, rs;

   if (SNAP_RELOAD) begin : g_snap
      logic [63:0] sb, sd, ss;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            sb <= '0; sd <= '0; ss <= '0;
         end else if (load) begin
            sb <= n_bytes; sd <= n_dst; ss <= n_src;
         end
      end
      assign rb = sb;
      assign rd = sd;
      assign rs = ss;
   end else begin : g_live
      assign rb = n_bytes;
      assign rd = n_dst;
      assign rs = n_src;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         x_cfg <= '0; x_bytes <= '0; x_dst <= '0; x_src <= '0;
      end else if (load) begin
         x_cfg   <= n_cfg;
         x_bytes <= n_bytes;
         x_dst   <= n_dst;
         x_src   <= n_src;
      end else if (done_ok && x_cfg[CFG_REPEAT]) begin
         x_bytes <= rb;
         x_dst   <= rd;
         x_src   <= rs;
      end else if (busy && adv) begin
         x_bytes <= (x_bytes - adv_amt) & XM;
         x_dst   <= (x_dst + adv_amt) & XM;
         x_src   <= (x_src + adv_amt) & XM;
      end
   end
endmodule

// File: rtl/dmab_ctrl.sv
module dmab_ctrl
   import dmab_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr,
   input  logic [31:0] wd,
   input  logic        eng_done,
   input  logic        eng_err,
   output logic [31:0] ctrl_q,
   output logic        busy,
   output logic        fire,
   output logic        start_q,
   output logic        irq_done,
   output logic        irq_err
);
   assign fire = wr && wd[CB_RUN] && !busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q  <= '0;
         busy    <= 1'b0;
         start_q <= 1'b0;
      end else begin
         start_q <= fire;
         if (wr) begin
            if (busy) begin
               ctrl_q <= (ctrl_q & ~CTRL_SW_BUSY) | (wd & CTRL_SW_BUSY);
            end else if (fire) begin
               ctrl_q <= wd & CTRL_KEEP & ~((32'd1 << CB_DONE) | (32'd1 << CB_ERR));
               busy   <= 1'b1;
            end else begin
               ctrl_q <= wd & CTRL_KEEP;
            end
         end
         if (busy && eng_err) begin
            ctrl_q[CB_ERR] <= 1'b1;
            busy           <= 1'b0;
         end else if (busy && eng_done) begin
            ctrl_q[CB_RUN]  <= 1'b0;
            ctrl_q[CB_DONE] <= 1'b1;
            busy            <= 1'b0;
         end
      end
   end

   assign irq_done = ctrl_q[CB_DIE] & ctrl_q[CB_DONE];
   assign irq_err  = ctrl_q[CB_EIE] & ctrl_q[CB_ERR];
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
   import dmab_pkg::*;
#(
   parameter int unsigned ADDR_W      = 12,
   parameter int unsigned XFER_W      = 64,
   parameter bit          SNAP_RELOAD = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_req,
   input  logic              bus_we,
   input  logic              bus_wide,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [63:0]       bus_wdata,
   output logic              bus_rvalid,
   output logic [63:0]       bus_rdata,
   output logic              eng_start,
   output logic [31:0]       eng_cfg,
   output logic [63:0]       eng_bytes,
   output logic [63:0]       eng_dst,
   output logic [63:0]       eng_src,
   input  logic              eng_adv,
   input  logic [63:0]       eng_adv_bytes,
   input  logic              eng_done,
   input  logic              eng_err,
   output logic              irq_done,
   output logic              irq_err
);
   localparam int unsigned WIDX_W = ADDR_W - 2;

   if (ADDR_W < 9 || ADDR_W > 32) begin : g_bad_addr_w
      $error("dma_chan_regs: ADDR_W must be within 9..32");
   end
   if (XFER_W < 8 || XFER_W > 64) begin : g_bad_xfer_w
      $error("dma_chan_regs: XFER_W must be within 8..64");
   end

   logic [WIDX_W-1:0] w0, w1;
   logic              acc_ok, wr_ok;
   assign w0     = bus_addr[ADDR_W-1:2];
   assign w1     = w0 + WIDX_W'(1);
   assign acc_ok = bus_req && (bus_addr[1:0] == 2'b00) && !(bus_wide && bus_addr[2]);
   assign wr_ok  = acc_ok && bus_we;

   function automatic logic word_hit(input logic [WIDX_W-1:0] k);
      return wr_ok && ((w0 == k) || (bus_wide && (w1 == k)));
   endfunction

   function automatic logic [31:0] word_data(input logic [WIDX_W-1:0] k);
      return (w0 == k) ? bus_wdata[31:0] : bus_wdata[63:32];
   endfunction

   // control and configuration words
   logic        ctrl_wr, busy, fire, done_ok;
   logic [31:0] ctrl_word, ncfg;
   assign ctrl_wr = word_hit(WIDX_W'(W_CTRL));
   assign done_ok = busy && eng_done && !eng_err;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                           ncfg <= '0;
      else if (word_hit(WIDX_W'(W_NCFG)))   ncfg <= word_data(WIDX_W'(W_NCFG));
   end

   dmab_ctrl u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr       (ctrl_wr),
      .wd       (word_data(WIDX_W'(W_CTRL))),
      .eng_done (eng_done),
      .eng_err  (eng_err),
      .ctrl_q   (ctrl_word),
      .busy     (busy),
      .fire     (fire),
      .start_q  (eng_start),
      .irq_done (irq_done),
      .irq_err  (irq_err)
   );

   // staged 64-bit descriptor registers
   logic [2*N_STAGE-1:0]       st_we;
   logic [2*N_STAGE-1:0][31:0] st_wd;
   logic [N_STAGE-1:0][63:0]   st_q;

   for (genvar j = 0; j < 2*N_STAGE; j++) begin : g_stage_word
      assign st_we[j] = word_hit(WIDX_W'(W_NBYT + j));
      assign st_wd[j] = word_data(WIDX_W'(W_NBYT + j));
   end

   dmab_stage #(.NREG(N_STAGE), .XFER_W(XFER_W)) u_stage (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (st_we),
      .wd    (st_wd),
      .q     (st_q)
   );

   logic [63:0] nx_bytes, nx_dst, nx_src;
   assign nx_bytes = st_q[0];
   assign nx_dst   = st_q[1];
   assign nx_src   = st_q[2];

   // execution copies
   logic [31:0] ex_cfg;
   logic [63:0] ex_bytes, ex_dst, ex_src;

   dmab_exec #(.XFER_W(XFER_W), .SNAP_RELOAD(SNAP_RELOAD)) u_exec (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (fire),
      .busy    (busy),
      .adv     (eng_adv),
      .adv_amt (eng_adv_bytes),
      .done_ok (done_ok),
      .n_cfg   (ncfg),
      .n_bytes (nx_bytes),
      .n_dst   (nx_dst),
      .n_src   (nx_src),
      .x_cfg   (ex_cfg),
      .x_bytes (ex_bytes),
      .x_dst   (ex_dst),
      .x_src   (ex_src)
   );

   assign eng_cfg   = ex_cfg;
   assign eng_bytes = ex_bytes;
   assign eng_dst   = ex_dst;
   assign eng_src   = ex_src;

   // read path
   function automatic logic [31:0] rd_word(input logic [WIDX_W-1:0] k);
      logic [31:0] v;
      case (k)
         WIDX_W'(W_CTRL):     v = ctrl_word;
         WIDX_W'(W_NCFG):     v = ncfg;
         WIDX_W'(W_NBYT):     v = nx_bytes[31:0];
         WIDX_W'(W_NBYT + 1): v = nx_bytes[63:32];
         WIDX_W'(W_NDST):     v = nx_dst[31:0];
         WIDX_W'(W_NDST + 1): v = nx_dst[63:32];
         WIDX_W'(W_NSRC):     v = nx_src[31:0];
         WIDX_W'(W_NSRC + 1): v = nx_src[63:32];
         WIDX_W'(W_XCFG):     v = ex_cfg;
         WIDX_W'(W_XBYT):     v = ex_bytes[31:0];
         WIDX_W'(W_XBYT + 1): v = ex_bytes[63:32];
         WIDX_W'(W_XDST):     v = ex_dst[31:0];
         WIDX_W'(W_XDST + 1): v = ex_dst[63:32];
         WIDX_W'(W_XSRC):     v = ex_src[31:0];
         WIDX_W'(W_XSRC + 1): v = ex_src[63:32];
         default:             v = '0;
      endcase
      return v;
   endfunction

   logic [63:0] rd_next;
   always_comb begin
      if (!acc_ok)       rd_next = '0;
      else if (bus_wide) rd_next = {rd_word(w1), rd_word(w0)};
      else               rd_next = {32'h0, rd_word(w0)};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bus_rvalid <= 1'b0;
         bus_rdata  <= '0;
      end else begin
         bus_rvalid <= bus_req && !bus_we;
         if (bus_req && !bus_we) bus_rdata <= rd_next;
      end
   end
endmodule

// File: rtl/dmab_chk.sv
module dmab_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        ctrl_wr,
   input logic [63:0] bus_wdata,
   input logic        busy,
   input logic        eng_start,
   input logic        eng_done,
   input logic        eng_err,
   input logic [31:0] ctrl_word,
   input logic [63:0] nx_bytes,
   input logic [63:0] ex_bytes
);
   AST_START_CLEARS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
      eng_start |-> (!ctrl_word[30] && !ctrl_word[31]));                         // R3
   AST_START_LOADS_EXEC: assert property (@(posedge clk) disable iff (!rst_n)
      eng_start |-> (ex_bytes == $past(nx_bytes)));                              // R3
   AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      eng_start |=> !eng_start);                                                 // R3
   AST_DONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && eng_done && !eng_err) |=> (ctrl_word[30] && !ctrl_word[1] && !busy)); // R5
   AST_ERR_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && eng_err) |=> (ctrl_word[31] && !ctrl_word[30] && !busy));         // R6
   AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && ctrl_wr && bus_wdata[1]) |=> !eng_start);                         // R11
   AST_EXEC_HELD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !(ctrl_wr && bus_wdata[1])) |=> $stable(ex_bytes));              // R9
endmodule

bind dma_chan_regs dmab_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .ctrl_wr   (ctrl_wr),
   .bus_wdata (bus_wdata),
   .busy      (busy),
   .eng_start (eng_start),
   .eng_done  (eng_done),
   .eng_err   (eng_err),
   .ctrl_word (ctrl_word),
   .nx_bytes  (nx_bytes),
   .ex_bytes  (ex_bytes)
);

// File: tb/tb_dma_chan_regs.sv
module tb_dma_chan_regs;
   localparam int unsigned ADDR_W = 12;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              bus_req = 1'b0, bus_we = 1'b0, bus_wide = 1'b0;
   logic [ADDR_W-1:0] bus_addr = '0;
   logic [63:0]       bus_wdata = '0;
   logic              bus_rvalid;
   logic [63:0]       bus_rdata;
   logic              eng_start;
   logic [31:0]       eng_cfg;
   logic [63:0]       eng_bytes, eng_dst, eng_src;
   logic              eng_adv = 1'b0;
   logic [63:0]       eng_adv_bytes = '0;
   logic              eng_done = 1'b0, eng_err = 1'b0;
   logic              irq_done, irq_err;

   int n_chk = 0;
   int n_bad = 0;

   always #2 clk = ~clk;

   dma_chan_regs #(.ADDR_W(ADDR_W)) dut (
      .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we), .bus_wide(bus_wide),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata),
      .eng_start(eng_start), .eng_cfg(eng_cfg), .eng_bytes(eng_bytes), .eng_dst(eng_dst),
      .eng_src(eng_src), .eng_adv(eng_adv), .eng_adv_bytes(eng_adv_bytes),
      .eng_done(eng_done), .eng_err(eng_err), .irq_done(irq_done), .irq_err(irq_err)
   );

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [11:0] a, input logic [63:0] d, input logic wide);
      @(negedge clk);
      bus_req = 1'b1; bus_we = 1'b1; bus_wide = wide; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_req = 1'b0; bus_we = 1'b0; bus_wide = 1'b0;
   endtask

   task automatic rd(input logic [11:0] a, input logic wide, output logic [63:0] d);
      @(negedge clk);
      bus_req = 1'b1; bus_we = 1'b0; bus_wide = wide; bus_addr = a;
      @(negedge clk);
      bus_req = 1'b0; bus_wide = 1'b0;
      d = bus_rdata;
      chk("R2 rvalid", {63'd0, bus_rvalid}, 64'd1);
   endtask

   task automatic rd_chk(input string tag, input logic [11:0] a, input logic wide,
                         input logic [63:0] exp);
      logic [63:0] d;
      rd(a, wide, d);
      chk(tag, d, exp);
   endtask

   task automatic pulse_adv(input logic [63:0] amt);
      @(negedge clk);
      eng_adv = 1'b1; eng_adv_bytes = amt;
      @(negedge clk);
      eng_adv = 1'b0;
   endtask

   task automatic pulse_end(input logic d, input logic e);
      @(negedge clk);
      eng_done = d; eng_err = e;
      @(negedge clk);
      eng_done = 1'b0; eng_err = 1'b0;
   endtask

   task automatic t_reset;
      chk("R1 rdata", bus_rdata, 64'd0);
      chk("R1 irq", {62'd0, irq_done, irq_err}, 64'd0);
      chk("R1 start", {63'd0, eng_start}, 64'd0);
      rd_chk("R1 ctrl", 12'h000, 1'b0, 64'd0);
      rd_chk("R1 exec count", 12'h108, 1'b1, 64'd0);
   endtask

   task automatic t_staged;
      wr(12'h008, 64'h1122_3344_5566_7788, 1'b1);
      rd_chk("R2 count high half", 12'h00C, 1'b0, 64'h1122_3344);
      rd_chk("R2 count low half", 12'h008, 1'b0, 64'h5566_7788);
      wr(12'h010, 64'hAAAA_0000, 1'b0);
      wr(12'h014, 64'h5, 1'b0);
      rd_chk("R2 dst wide", 12'h010, 1'b1, 64'h0000_0005_AAAA_0000);
      wr(12'h004, 64'h0000_0000_0000_0004, 1'b0);
      rd_chk("R2 cfg", 12'h004, 1'b0, 64'h4);
   endtask

   task automatic t_ctrl_bits;
      wr(12'h000, 64'h0000_C001, 1'b0);
      rd_chk("R12 claim and enables", 12'h000, 1'b0, 64'h0000_C001);
      wr(12'h000, 64'h3FFF_3FFC, 1'b0);
      rd_chk("R12 reserved bits", 12'h000, 1'b0, 64'h0);
   endtask

   task automatic t_start;
      wr(12'h004, 64'h0, 1'b0);
      wr(12'h008, 64'h40, 1'b1);
      wr(12'h010, 64'h2000, 1'b1);
      wr(12'h018, 64'h1000, 1'b1);
      wr(12'h000, 64'hC000_C002, 1'b0);
      chk("R3 start pulse", {63'd0, eng_start}, 64'd1);
      @(negedge clk);
      chk("R3 pulse one cycle", {63'd0, eng_start}, 64'd0);
      rd_chk("R3 flags cleared", 12'h000, 1'b0, 64'h0000_C002);
      rd_chk("R3 exec count", 12'h108, 1'b1, 64'h40);
      rd_chk("R3 exec dst", 12'h110, 1'b1, 64'h2000);
      rd_chk("R3 exec src", 12'h118, 1'b1, 64'h1000);
      chk("R3 engine src", eng_src, 64'h1000);
   endtask

   task automatic t_exec_ro;
      wr(12'h108, 64'hFFFF, 1'b1);
      wr(12'h104, 64'h4, 1'b0);
      rd_chk("R9 exec count kept", 12'h108, 1'b1, 64'h40);
      rd_chk("R9 exec cfg kept", 12'h104, 1'b0, 64'h0);
   endtask

   task automatic t_busy_run;
      wr(12'h000, 64'h0000_0003, 1'b0);
      chk("R11 no second start", {63'd0, eng_start}, 64'd0);
      rd_chk("R11 ctrl while busy", 12'h000, 1'b0, 64'h0000_0003);
      rd_chk("R11 exec unchanged", 12'h108, 1'b1, 64'h40);
   endtask

   task automatic t_advance;
      pulse_adv(64'h10);
      pulse_adv(64'h10);
      rd_chk("R4 exec count", 12'h108, 1'b1, 64'h20);
      rd_chk("R4 exec src", 12'h118, 1'b1, 64'h1020);
      rd_chk("R4 exec dst", 12'h110, 1'b1, 64'h2020);
   endtask

   task automatic t_done;
      wr(12'h000, 64'h0000_4003, 1'b0);
      chk("R8 no irq before done", {63'd0, irq_done}, 64'd0);
      pulse_end(1'b1, 1'b0);
      chk("R8 irq_done", {63'd0, irq_done}, 64'd1);
      rd_chk("R5 ctrl after done", 12'h000, 1'b0, 64'h4000_4001);
      rd_chk("R7 no repeat keeps count", 12'h108, 1'b1, 64'h20);
      pulse_adv(64'h8);
      rd_chk("R4 idle beat ignored", 12'h108, 1'b1, 64'h20);
      wr(12'h000, 64'h0000_4001, 1'b0);
      chk("R8 ack drops irq_done", {63'd0, irq_done}, 64'd0);
   endtask

   task automatic t_repeat;
      wr(12'h004, 64'h4, 1'b0);
      wr(12'h008, 64'h80, 1'b1);
      wr(12'h010, 64'h3000, 1'b1);
      wr(12'h018, 64'h5000, 1'b1);
      wr(12'h000, 64'h2, 1'b0);
      chk("R3 repeat start", {63'd0, eng_start}, 64'd1);
      wr(12'h008, 64'h999, 1'b1);
      wr(12'h018, 64'h7777, 1'b1);
      pulse_adv(64'h40);
      rd_chk("R4 mid count", 12'h108, 1'b1, 64'h40);
      pulse_end(1'b1, 1'b0);
      rd_chk("R7 count restored", 12'h108, 1'b1, 64'h80);
      rd_chk("R7 src restored", 12'h118, 1'b1, 64'h5000);
      rd_chk("R7 dst restored", 12'h110, 1'b1, 64'h3000);
      rd_chk("R5 run cleared", 12'h000, 1'b0, 64'h4000_0000);
   endtask

   task automatic t_error;
      wr(12'h004, 64'h0, 1'b0);
      wr(12'h000, 64'h0000_8002, 1'b0);
      chk("R3 start for error case", {63'd0, eng_start}, 64'd1);
      pulse_end(1'b1, 1'b1);
      chk("R6 irq_err", {63'd0, irq_err}, 64'd1);
      chk("R6 no irq_done", {63'd0, irq_done}, 64'd0);
      rd_chk("R6 ctrl after error", 12'h000, 1'b0, 64'h8000_8002);
      wr(12'h000, 64'h0000_8002, 1'b0);
      chk("R6 restart after error", {63'd0, eng_start}, 64'd1);
      chk("R8 flag cleared drops irq_err", {63'd0, irq_err}, 64'd0);
      pulse_end(1'b1, 1'b0);
      rd_chk("R5 second finish", 12'h000, 1'b0, 64'h4000_8000);
   endtask

   task automatic t_unmapped;
      wr(12'h020, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1);
      rd_chk("R10 unmapped read", 12'h020, 1'b1, 64'h0);
      rd_chk("R10 gap read", 12'h100, 1'b0, 64'h0);
      wr(12'h00C, 64'hDEAD_BEEF_0BAD_F00D, 1'b1);
      rd_chk("R10 misaligned wide write ignored", 12'h008, 1'b1, 64'h999);
      rd_chk("R10 misaligned wide read", 12'h00C, 1'b1, 64'h0);
      wr(12'h009, 64'h1234, 1'b0);
      rd_chk("R10 byte-offset write ignored", 12'h008, 1'b0, 64'h999);
      rd_chk("R10 byte-offset read", 12'h009, 1'b0, 64'h0);
   endtask

   initial begin
      #(200000 * 4);
      n_bad++;
      $display("FAIL watchdog: actual still running, expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_staged();
      t_ctrl_bits();
      t_start();
      t_exec_ro();
      t_busy_run();
      t_advance();
      t_done();
      t_repeat();
      t_error();
      t_unmapped();
      repeat (2) @(negedge clk);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule